// File: doc/BRIEF.md
# Fast-Blanking Skew and Polarity Control

This block produces the fast-blanking switch for an on-screen display, together with the RGB pixel bus that goes with it. Every cycle of the line-locked pixel clock it takes a raw flag that marks pixels where the display's own RGB should be shown, plus a 3-bit-per-colour RGB word. The RGB word leaves the block after a fixed two-clock latency. The switch flag goes down a short tap line. The output is picked from one of three taps, so the switch can lead the RGB bus by one clock, line up with it, or trail it by one clock. This compensates for the unequal delays of external buffers on the two paths.

A polarity control sets the sense of the switch pin, so the block can drive either an active-high or an active-low switch input. Alignment and polarity are plain input pins. They are sampled on every clock edge and take effect on the output after that edge. The pixel path has no valid/ready handshake: the display clock is locked to the line and cannot stall, so a sample is taken on every edge and there is no back-pressure.

Top module: `fb_skew_ctrl`

## Requirements
- R1: `rgb_o` equals the `rgb_i` value sampled two rising edges earlier. The colour fields are bits 8:6 red, 5:3 green and 2:0 blue, and they pass through unchanged.
- R2: With alignment code 3'b000, the switch is coincident: before polarity, `fb_o` follows `disp_rgb_i` with the same two-clock delay as RGB.
- R3: With alignment code 3'b001, the switch leads: `fb_o` follows `disp_rgb_i` with a one-clock delay, one clock ahead of the matching RGB word.
- R4: With alignment code 3'b010, the switch lags: `fb_o` follows `disp_rgb_i` with a three-clock delay, one clock behind the matching RGB word.
- R5: Alignment codes 3'b011 through 3'b111 behave exactly like 3'b000.
- R6: With `fb_invert_i` at 0, `fb_o` high selects RGB display and low selects video.
- R7: With `fb_invert_i` at 1, the switch is inverted: `fb_o` low selects RGB display and high selects video.
- R8: A new alignment or polarity value sampled at an edge governs `fb_o` right after that edge. Flag history already held in the tap line is kept, so a change causes at most one discontinuous cycle.
- R9: A synchronous reset clears every delay stage. While the reset is held, `rgb_o` is zero and `fb_o` shows video for the polarity sampled at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_rgb_i | input | 1 | Raw flag: show display RGB for this pixel |
| rgb_i | input | 9 | Pixel colour, 3 bits each for R, G, B |
| fb_invert_i | input | 1 | Switch polarity select (1 = active low) |
| fb_align_i | input | 3 | Switch alignment code |
| rgb_o | output | 9 | Pixel colour after two clocks |
| fb_o | output | 1 | Aligned, polarity-adjusted fast-blanking switch |

## Verification
A change of the alignment or polarity setting can land on the same edge as a transition of the display flag. When that happens, the tap selection, the inversion and the flag history all act together on the same output cycle. The bench runs every polarity against all eight alignment codes and switches the setting in the middle of flag activity. It checks the output on the very first cycle after each change, using a recorded input history. A reset applied while the flag and RGB are active is checked for cleared stages and for the idle switch level under the inverted polarity.

// File: rtl/fbskew_pkg.sv
package fbskew_pkg;

  typedef enum logic [1:0] {
    ALN_EARLY = 2'd0,
    ALN_COINC = 2'd1,
    ALN_LATE  = 2'd2
  } align_e;

  localparam int unsigned TAP_COUNT = 3;

  // Unlisted codes fall back to coincident alignment.
  function automatic align_e decode_align(input logic [2:0] code);
    case (code)
      3'b001:  return ALN_EARLY;
      3'b010:  return ALN_LATE;
      default: return ALN_COINC;
    endcase
  endfunction

  // Tap k carries the flag delayed by k+1 clocks.
  function automatic logic [1:0] tap_of(input align_e a);
    case (a)
      ALN_EARLY: return 2'd0;
      ALN_LATE:  return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/fb_pixel_pipe.sv
module fb_pixel_pipe #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] tail_o
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= data_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign tail_o = stage_q[DEPTH-1];

  // R9: reset empties the pixel pipe
  p_pipe_clear_r9: assert property (@(posedge clk) rst |=> (tail_o == '0));

endmodule

// File: rtl/fb_flag_taps.sv
module fb_flag_taps #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_i,
  output logic [DEPTH-1:0] taps_o
);

  logic [DEPTH-1:0] tap_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) tap_q[g] <= 1'b0;
        else     tap_q[g] <= flag_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) tap_q[g] <= 1'b0;
        else     tap_q[g] <= tap_q[g-1];
      end
    end
  end

  assign taps_o = tap_q;

  // R9: every flag tap is empty after a reset edge
  p_taps_clear_r9: assert property (@(posedge clk) rst |=> (taps_o == '0));

endmodule

// File: rtl/fb_switch_out.sv
module fb_switch_out
  import fbskew_pkg::*;
#(
  parameter int DEPTH = TAP_COUNT
) (
  input  logic             clk,
  input  logic [DEPTH-1:0] taps_i,
  input  logic [2:0]       align_code_i,
  input  logic             invert_i,
  output logic             fb_o
);

  // Settings are registered without reset, so the idle level during
  // reset already reflects the polarity in force.
  align_e align_q;
  logic   invert_q;

  always_ff @(posedge clk) begin
    align_q  <= decode_align(align_code_i);
    invert_q <= invert_i;
  end

  logic picked;
  always_comb begin
    picked = taps_i[tap_of(align_q)];
  end

  assign fb_o = picked ^ invert_q;

endmodule

// File: rtl/fb_skew_ctrl.sv
module fb_skew_ctrl
  import fbskew_pkg::*;
#(
  parameter int COLOR_BITS = 3,
  parameter int RGB_W      = 3 * COLOR_BITS,
  parameter int RGB_LAT    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_rgb_i,
  input  logic [RGB_W-1:0] rgb_i,
  input  logic             fb_invert_i,
  input  logic [2:0]       fb_align_i,
  output logic [RGB_W-1:0] rgb_o,
  output logic             fb_o
);

  localparam int FLAG_TAPS = RGB_LAT + 1;

  logic [FLAG_TAPS-1:0] flag_taps;

  fb_pixel_pipe #(.WIDTH(RGB_W), .DEPTH(RGB_LAT)) u_pixel_pipe (
    .clk    (clk),
    .rst    (rst),
    .data_i (rgb_i),
    .tail_o (rgb_o)
  );

  fb_flag_taps #(.DEPTH(FLAG_TAPS)) u_flag_taps (
    .clk    (clk),
    .rst    (rst),
    .flag_i (disp_rgb_i),
    .taps_o (flag_taps)
  );

  fb_switch_out #(.DEPTH(FLAG_TAPS)) u_switch_out (
    .clk          (clk),
    .taps_i       (flag_taps),
    .align_code_i (fb_align_i),
    .invert_i     (fb_invert_i),
    .fb_o         (fb_o)
  );

  // Edges since reset, saturating; it gates history-based checks.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R1: fixed two-clock RGB latency
  p_rgb_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (rgb_o == $past(rgb_i, 2)));

  // R2, R6, R7, R8: coincident switch under the polarity just sampled
  p_coinc_r2: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2 && $past(fb_align_i) == 3'b000)
      |-> (fb_o == ($past(disp_rgb_i, 2) ^ $past(fb_invert_i))));

  // R3: switch one clock ahead of RGB
  p_early_r3: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd1 && $past(fb_align_i) == 3'b001)
      |-> (fb_o == ($past(disp_rgb_i) ^ $past(fb_invert_i))));

  // R4: switch one clock behind RGB
  p_late_r4: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3 && $past(fb_align_i) == 3'b010)
      |-> (fb_o == ($past(disp_rgb_i, 3) ^ $past(fb_invert_i))));

  // R5: spare codes align like the coincident code
  p_alias_r5: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2 && $past(fb_align_i) >= 3'b011)
      |-> (fb_o == ($past(disp_rgb_i, 2) ^ $past(fb_invert_i))));

  // R9: during reset the switch sits at the video level
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (fb_o == $past(fb_invert_i)));

endmodule

// File: tb/fb_skew_ctrl_bench.sv
module fb_skew_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RGB_W      = 9;

  logic             clk = 1'b0;
  logic             rst;
  logic             disp;
  logic [RGB_W-1:0] rgb;
  logic             inv;
  logic [2:0]       aln;
  logic [RGB_W-1:0] rgb_o;
  logic             fb_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_skew_ctrl u_fb_skew_ctrl (
    .clk         (clk),
    .rst         (rst),
    .disp_rgb_i  (disp),
    .rgb_i       (rgb),
    .fb_invert_i (inv),
    .fb_align_i  (aln),
    .rgb_o       (rgb_o),
    .fb_o        (fb_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int since  = 0;
  logic             h_disp [8];
  logic [RGB_W-1:0] h_rgb  [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic r, input logic d, input logic [RGB_W-1:0] p,
                      input logic iv, input logic [2:0] a, input bit new_cfg);
    int dly;
    string tag;
    rst = r; disp = d; rgb = p; inv = iv; aln = a;
    @(posedge clk);
    h_disp[cyc % 8] = d;
    h_rgb[cyc % 8]  = p;
    if (r) since = 0; else since++;
    @(negedge clk);
    if (r) begin
      check(rgb_o == '0, "R9 rgb cleared", int'(rgb_o), 0);
      check(fb_o == iv, "R9 video level in reset", int'(fb_o), int'(iv));
    end else begin
      if (since >= 2)
        check(rgb_o == h_rgb[(cyc - 1) % 8], "R1 rgb latency",
              int'(rgb_o), int'(h_rgb[(cyc - 1) % 8]));
      dly = (a == 3'b001) ? 1 : (a == 3'b010) ? 3 : 2;
      tag = (a == 3'b000) ? "R2" : (a == 3'b001) ? "R3" : (a == 3'b010) ? "R4" : "R5";
      tag = {tag, iv ? " R7" : " R6", new_cfg ? " R8" : ""};
      if (since >= dly)
        check(fb_o == (h_disp[(cyc - dly + 1) % 8] ^ iv), tag,
              int'(fb_o), int'(h_disp[(cyc - dly + 1) % 8] ^ iv));
    end
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state, both polarities
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 9'h1FF, k[0], 3'b000, 1'b0);

    // Sweep every polarity and alignment code with distinct flag patterns
    for (int pol = 0; pol < 2; pol++) begin
      for (int al = 0; al < 8; al++) begin
        for (int n = 0; n < 24; n++) begin
          logic f;
          logic [RGB_W-1:0] px;
          f  = (((n * (al + 3) + pol * 7 + (n >> 2)) % 5) < 2);
          px = RGB_W'((n * 37 + al * 11 + pol * 101) % 512);
          step(1'b0, f, px, pol[0], al[2:0], n == 0);
        end
      end
    end

    // R8: setting flips on every cycle while the flag toggles
    for (int n = 0; n < 32; n++)
      step(1'b0, n[0] ^ n[2], RGB_W'(n * 13), n[1], 3'((n * 3) % 8), 1'b1);

    // R9: reset in mid-stream with inverted polarity, then recovery
    for (int n = 0; n < 2; n++) step(1'b1, 1'b1, 9'h155, 1'b1, 3'b010, 1'b0);
    for (int n = 0; n < 8; n++) step(1'b0, n[1], RGB_W'(n * 61), 1'b1, 3'b010, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule